// File: doc/BRIEF.md
# Trap Entry Sequencer

This block performs the entry half of trap handling for a small 32-bit soft processor. Each cycle it may see one-cycle requests for a hardware exception, a memory-management fault, an external interrupt and a hardware break. With them it receives the current program counter, a flag that marks an instruction in a branch delay slot, the pending branch target, the faulting address and the current machine status word. When it accepts a request, it works out everything the core needs to enter the handler. That is the handler address, a link-register write, a new status word and new syndrome, fault-address and branch-target values. It also issues a flush strobe. The flush strobe also tells the core to drop any load reservation and any immediate-prefix or delay-slot state it holds.

A small state machine controls the sequencing. It has three states. ST_IDLE accepts requests. ST_COMMIT is the single cycle in which every registered result is presented together. ST_FATAL is entered when a second translation fault arrives while one is still being handled, and it is left only by reset. The transitions are:

- ST_IDLE to ST_FATAL on a recursive fault.
- ST_IDLE to ST_COMMIT on any accepted request.
- ST_COMMIT to ST_IDLE unconditionally.
- ST_FATAL to itself.

Top module: `trap_entry_seq`

## Requirements
- R1: When several requests arrive in one cycle, exactly one is served, with the translation fault first, then the hardware exception, then the break, then the interrupt. The served cause shows as the link index: 17 for a fault or exception, 16 for a break, 14 for an interrupt.
- R2: The new PC is the vector base plus 0x20 for exceptions and translation faults, plus 0x18 for breaks, and plus 0x10 for interrupts.
- R3: The link data is the faulting PC plus 4 for a hardware exception. It is the PC itself for a translation fault, a break or an interrupt.
- R4: For exceptions and faults, syndrome bit 12 equals the delay-slot flag. The branch-target register is written with the pending target only when that flag is set. Breaks and interrupts write neither.
- R5: On every entry, status bit 11 (user mode) moves to bit 12, and bit 13 (translation on) moves to bit 14. Bits 11 and 13 become 0.
- R6: Exception and fault entries set status bit 9 (exception in progress). Break entry sets bit 3 (break in progress). Interrupt entry clears bit 1 (interrupt enable). All other status bits pass through unchanged.
- R7: A translation fault writes the syndrome low bits as follows: 16 for a data miss, 17 for a fetch miss, 18 for a data protection fault and 19 for a fetch protection fault. Syndrome bit 10 is set for a store. The fault address is written to the address register. A hardware exception writes its 5-bit cause into the syndrome low bits and does not write the address register.
- R8: A fault request that arrives while a previous fault entry is still in progress (status bit 9 set, and no idle cycle with bit 9 clear since that entry) raises a sticky fatal flag. After that, no request is served until reset.
- R9: An interrupt is served only when status bit 1 is 1 and bits 9 and 3 are both 0. Otherwise it is ignored.
- R10: A hardware exception request made while exceptions are reported unsupported produces a one-cycle error pulse and no entry. Lower-priority requests in the same cycle are served as if it were absent.
- R11: All results, and a single-cycle flush strobe, appear together one cycle after the request is sampled. Requests sampled during that commit cycle are ignored.
- R12: After reset, the flush, every write strobe, the error pulse and the fatal flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_hwexc | input | 1 | Hardware exception request |
| exc_cause | input | 5 | Cause code for a hardware exception |
| exc_supported | input | 1 | Core is configured with exception support |
| req_mmu | input | 1 | Translation fault request |
| mmu_prot | input | 1 | Fault is a protection violation (0: miss) |
| mmu_fetch | input | 1 | Fault came from an instruction fetch |
| mmu_store | input | 1 | Faulting access was a store |
| fault_addr | input | 32 | Faulting virtual address |
| req_irq | input | 1 | External interrupt request |
| req_brk | input | 1 | Hardware break request |
| cur_pc | input | 32 | PC of the trapped instruction |
| in_dslot | input | 1 | Trapped instruction sits in a delay slot |
| br_target | input | 32 | Pending branch target |
| vec_base | input | 32 | Vector base address |
| msr_in | input | 32 | Current machine status word |
| flush | output | 1 | Commit and pipeline flush strobe |
| new_pc | output | 32 | Handler address |
| lr_we | output | 1 | Link register write enable |
| lr_addr | output | 5 | Link register index |
| lr_data | output | 32 | Link register value |
| msr_out | output | 32 | New status word, valid with flush |
| esr_we | output | 1 | Syndrome write enable |
| esr_out | output | 32 | New syndrome value |
| ear_we | output | 1 | Fault address register write enable |
| ear_out | output | 32 | Fault address value |
| btr_we | output | 1 | Branch target register write enable |
| btr_out | output | 32 | Branch target value |
| unsup_err | output | 1 | Unsupported-exception error pulse |
| fatal_err | output | 1 | Sticky recursive-fault flag |

## Verification
Every result of an entry, including the error pulse and the fatal flag, is registered once. It is therefore due at the falling edge after the rising edge that samples the request. The bench drives a request at one falling edge and compares all outputs at the next. At the following falling edge it confirms that the strobes have dropped, or, for a request held into the commit cycle, that the request produced no second entry. The fatal flag is checked at that same first falling edge and again after later requests, to show that it holds and that nothing further is served.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [2:0] {
        TK_NONE,
        TK_MMU,
        TK_HWEXC,
        TK_BREAK,
        TK_IRQ
    } trap_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COMMIT,
        ST_FATAL
    } seq_state_e;

    // status word bit positions; shadow bits sit one place above live bits
    localparam int MSR_IE  = 1;
    localparam int MSR_BIP = 3;
    localparam int MSR_EIP = 9;
    localparam int MSR_UM  = 11;
    localparam int MSR_UMS = 12;
    localparam int MSR_VM  = 13;
    localparam int MSR_VMS = 14;

    // syndrome bit positions and fault codes
    localparam int ESR_STORE = 10;
    localparam int ESR_DSLOT = 12;
    localparam int ESR_CODE_W = 5;
    localparam logic [ESR_CODE_W-1:0] ESR_MISS_DATA  = 5'd16;
    localparam logic [ESR_CODE_W-1:0] ESR_MISS_FETCH = 5'd17;
    localparam logic [ESR_CODE_W-1:0] ESR_PROT_DATA  = 5'd18;
    localparam logic [ESR_CODE_W-1:0] ESR_PROT_FETCH = 5'd19;

    // link register indices
    localparam int LR_IRQ = 14;
    localparam int LR_BRK = 16;
    localparam int LR_EXC = 17;

    // vector offsets from the base
    localparam int OFS_IRQ = 'h10;
    localparam int OFS_BRK = 'h18;
    localparam int OFS_EXC = 'h20;

    localparam int INSN_BYTES = 4;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic       req_mmu,
    input  logic       req_hwexc,
    input  logic       exc_supported,
    input  logic       req_brk,
    input  logic       req_irq,
    input  logic       irq_enabled,
    output trap_kind_e kind,
    output logic       unsup_req
);

    logic hwexc_ok;
    logic irq_ok;

    assign hwexc_ok  = req_hwexc & exc_supported;
    assign irq_ok    = req_irq & irq_enabled;
    assign unsup_req = req_hwexc & ~exc_supported;

    always_comb begin
        if (req_mmu) begin
            kind = TK_MMU;
        end else if (hwexc_ok) begin
            kind = TK_HWEXC;
        end else if (req_brk) begin
            kind = TK_BREAK;
        end else if (irq_ok) begin
            kind = TK_IRQ;
        end else begin
            kind = TK_NONE;
        end
    end

endmodule

// File: rtl/trap_msr_calc.sv
module trap_msr_calc
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] msr_in,
    input  trap_kind_e      kind,
    output logic [XLEN-1:0] msr_next
);

    always_comb begin
        msr_next          = msr_in;
        // park translation and user mode in their shadows, then drop them
        msr_next[MSR_UMS] = msr_in[MSR_UM];
        msr_next[MSR_VMS] = msr_in[MSR_VM];
        msr_next[MSR_UM]  = 1'b0;
        msr_next[MSR_VM]  = 1'b0;
        case (kind)
            TK_MMU, TK_HWEXC: msr_next[MSR_EIP] = 1'b1;
            TK_BREAK:         msr_next[MSR_BIP] = 1'b1;
            TK_IRQ:           msr_next[MSR_IE]  = 1'b0;
            default:          ;
        endcase
    end

endmodule

// File: rtl/trap_esr_calc.sv
module trap_esr_calc
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  trap_kind_e          kind,
    input  logic                in_dslot,
    input  logic                mmu_prot,
    input  logic                mmu_fetch,
    input  logic                mmu_store,
    input  logic [CAUSE_W-1:0]  exc_cause,
    output logic [XLEN-1:0]     esr_next
);

    logic [ESR_CODE_W-1:0] fault_code;

    always_comb begin
        case ({mmu_prot, mmu_fetch})
            2'b00:   fault_code = ESR_MISS_DATA;
            2'b01:   fault_code = ESR_MISS_FETCH;
            2'b10:   fault_code = ESR_PROT_DATA;
            default: fault_code = ESR_PROT_FETCH;
        endcase
    end

    always_comb begin
        esr_next = '0;
        case (kind)
            TK_MMU: begin
                esr_next[ESR_CODE_W-1:0] = fault_code;
                esr_next[ESR_STORE]      = mmu_store;
                esr_next[ESR_DSLOT]      = in_dslot;
            end
            TK_HWEXC: begin
                esr_next[CAUSE_W-1:0]    = exc_cause;
                esr_next[ESR_DSLOT]      = in_dslot;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int RF_AW   = 5,
    parameter int CAUSE_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_hwexc,
    input  logic [CAUSE_W-1:0]  exc_cause,
    input  logic                exc_supported,
    input  logic                req_mmu,
    input  logic                mmu_prot,
    input  logic                mmu_fetch,
    input  logic                mmu_store,
    input  logic [XLEN-1:0]     fault_addr,
    input  logic                req_irq,
    input  logic                req_brk,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic                in_dslot,
    input  logic [XLEN-1:0]     br_target,
    input  logic [XLEN-1:0]     vec_base,
    input  logic [XLEN-1:0]     msr_in,
    output logic                flush,
    output logic [XLEN-1:0]     new_pc,
    output logic                lr_we,
    output logic [RF_AW-1:0]    lr_addr,
    output logic [XLEN-1:0]     lr_data,
    output logic [XLEN-1:0]     msr_out,
    output logic                esr_we,
    output logic [XLEN-1:0]     esr_out,
    output logic                ear_we,
    output logic [XLEN-1:0]     ear_out,
    output logic                btr_we,
    output logic [XLEN-1:0]     btr_out,
    output logic                unsup_err,
    output logic                fatal_err
);

    localparam logic [XLEN-1:0]  VEC_EXC  = XLEN'(OFS_EXC);
    localparam logic [XLEN-1:0]  VEC_BRK  = XLEN'(OFS_BRK);
    localparam logic [XLEN-1:0]  VEC_IRQ  = XLEN'(OFS_IRQ);
    localparam logic [XLEN-1:0]  PC_STEP  = XLEN'(INSN_BYTES);
    localparam logic [RF_AW-1:0] LRA_EXC  = RF_AW'(LR_EXC);
    localparam logic [RF_AW-1:0] LRA_BRK  = RF_AW'(LR_BRK);
    localparam logic [RF_AW-1:0] LRA_IRQ  = RF_AW'(LR_IRQ);

    seq_state_e       state_q;
    seq_state_e       state_d;
    trap_kind_e       kind;
    logic             unsup_req;
    logic             irq_enabled;
    logic             mmu_active_q;
    logic             recursive;
    logic             accept;
    logic             exc_like;
    logic [XLEN-1:0]  msr_next;
    logic [XLEN-1:0]  esr_next;
    logic [XLEN-1:0]  vec_ofs;
    logic [RF_AW-1:0] lr_sel;
    logic [XLEN-1:0]  lr_val;

    assign irq_enabled = msr_in[MSR_IE] & ~msr_in[MSR_EIP] & ~msr_in[MSR_BIP];
    assign recursive   = req_mmu & mmu_active_q & msr_in[MSR_EIP];
    assign exc_like    = (kind == TK_MMU) || (kind == TK_HWEXC);

    trap_arbiter arb_i (
        .req_mmu       (req_mmu),
        .req_hwexc     (req_hwexc),
        .exc_supported (exc_supported),
        .req_brk       (req_brk),
        .req_irq       (req_irq),
        .irq_enabled   (irq_enabled),
        .kind          (kind),
        .unsup_req     (unsup_req)
    );

    trap_msr_calc #(.XLEN(XLEN)) msr_i (
        .msr_in   (msr_in),
        .kind     (kind),
        .msr_next (msr_next)
    );

    trap_esr_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) esr_i (
        .kind      (kind),
        .in_dslot  (in_dslot),
        .mmu_prot  (mmu_prot),
        .mmu_fetch (mmu_fetch),
        .mmu_store (mmu_store),
        .exc_cause (exc_cause),
        .esr_next  (esr_next)
    );

    // per-cause vector offset and link register
    always_comb begin
        vec_ofs = '0;
        lr_sel  = '0;
        lr_val  = cur_pc;
        case (kind)
            TK_MMU: begin
                vec_ofs = VEC_EXC;
                lr_sel  = LRA_EXC;
            end
            TK_HWEXC: begin
                vec_ofs = VEC_EXC;
                lr_sel  = LRA_EXC;
                lr_val  = cur_pc + PC_STEP;
            end
            TK_BREAK: begin
                vec_ofs = VEC_BRK;
                lr_sel  = LRA_BRK;
            end
            TK_IRQ: begin
                vec_ofs = VEC_IRQ;
                lr_sel  = LRA_IRQ;
            end
            default: ;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (recursive) begin
                    state_d = ST_FATAL;
                end else if (kind != TK_NONE) begin
                    state_d = ST_COMMIT;
                end
            end
            ST_COMMIT: state_d = ST_IDLE;
            ST_FATAL:  state_d = ST_FATAL;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && (state_d == ST_COMMIT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush        <= 1'b0;
            new_pc       <= '0;
            lr_we        <= 1'b0;
            lr_addr      <= '0;
            lr_data      <= '0;
            msr_out      <= '0;
            esr_we       <= 1'b0;
            esr_out      <= '0;
            ear_we       <= 1'b0;
            ear_out      <= '0;
            btr_we       <= 1'b0;
            btr_out      <= '0;
            unsup_err    <= 1'b0;
            fatal_err    <= 1'b0;
            mmu_active_q <= 1'b0;
        end else begin
            flush     <= 1'b0;
            lr_we     <= 1'b0;
            esr_we    <= 1'b0;
            ear_we    <= 1'b0;
            btr_we    <= 1'b0;
            unsup_err <= (state_q == ST_IDLE) && unsup_req && !recursive;
            fatal_err <= (state_d == ST_FATAL);
            if (accept) begin
                flush   <= 1'b1;
                new_pc  <= vec_base + vec_ofs;
                lr_we   <= 1'b1;
                lr_addr <= lr_sel;
                lr_data <= lr_val;
                msr_out <= msr_next;
                if (exc_like) begin
                    esr_we  <= 1'b1;
                    esr_out <= esr_next;
                    btr_we  <= in_dslot;
                    btr_out <= br_target;
                end
                if (kind == TK_MMU) begin
                    ear_we  <= 1'b1;
                    ear_out <= fault_addr;
                end
            end
            // a fault entry stays live until an idle cycle shows bit 9 clear
            if (accept && kind == TK_MMU) begin
                mmu_active_q <= 1'b1;
            end else if (state_q == ST_IDLE && !msr_in[MSR_EIP]) begin
                mmu_active_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int RF_AW = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic [XLEN-1:0]  new_pc,
    input logic [XLEN-1:0]  vec_base,
    input logic             lr_we,
    input logic [RF_AW-1:0] lr_addr,
    input logic [XLEN-1:0]  msr_in,
    input logic [XLEN-1:0]  msr_out,
    input logic             fatal_err,
    input logic             unsup_err,
    input logic             req_hwexc,
    input logic             exc_supported
);

    assert_flush_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    assert_link_with_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> flush);

    assert_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (new_pc == $past(vec_base) + XLEN'(OFS_EXC)) ||
                  (new_pc == $past(vec_base) + XLEN'(OFS_BRK)) ||
                  (new_pc == $past(vec_base) + XLEN'(OFS_IRQ)));

    assert_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (msr_out[MSR_UMS] == $past(msr_in[MSR_UM])) &&
                  (msr_out[MSR_VMS] == $past(msr_in[MSR_VM])) &&
                  !msr_out[MSR_UM] && !msr_out[MSR_VM]);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lr_addr == RF_AW'(LR_IRQ)) |->
            $past(msr_in[MSR_IE] && !msr_in[MSR_EIP] && !msr_in[MSR_BIP]));

    assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |=> fatal_err && !flush);

    assert_unsup_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_err |-> $past(req_hwexc && !exc_supported));

endmodule

bind trap_entry_seq trap_entry_chk #(.XLEN(XLEN), .RF_AW(RF_AW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .new_pc        (new_pc),
    .vec_base      (vec_base),
    .lr_we         (lr_we),
    .lr_addr       (lr_addr),
    .msr_in        (msr_in),
    .msr_out       (msr_out),
    .fatal_err     (fatal_err),
    .unsup_err     (unsup_err),
    .req_hwexc     (req_hwexc),
    .exc_supported (exc_supported)
);

// File: tb/trap_entry_seq_tb_top.sv
module trap_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_hwexc = 1'b0;
    logic [4:0]  exc_cause = '0;
    logic        exc_supported = 1'b1;
    logic        req_mmu = 1'b0;
    logic        mmu_prot = 1'b0;
    logic        mmu_fetch = 1'b0;
    logic        mmu_store = 1'b0;
    logic [31:0] fault_addr = '0;
    logic        req_irq = 1'b0;
    logic        req_brk = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        in_dslot = 1'b0;
    logic [31:0] br_target = '0;
    logic [31:0] vec_base = 32'h0000_4000;
    logic [31:0] msr_in = '0;
    logic        flush;
    logic [31:0] new_pc;
    logic        lr_we;
    logic [4:0]  lr_addr;
    logic [31:0] lr_data;
    logic [31:0] msr_out;
    logic        esr_we;
    logic [31:0] esr_out;
    logic        ear_we;
    logic [31:0] ear_out;
    logic        btr_we;
    logic [31:0] btr_out;
    logic        unsup_err;
    logic        fatal_err;

    int n_checks = 0;
    int n_fail   = 0;

    // 50 MHz: 20 time-unit period (ns)
    always #10 clk = ~clk;

    trap_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_hwexc(req_hwexc), .exc_cause(exc_cause),
        .exc_supported(exc_supported), .req_mmu(req_mmu), .mmu_prot(mmu_prot),
        .mmu_fetch(mmu_fetch), .mmu_store(mmu_store), .fault_addr(fault_addr),
        .req_irq(req_irq), .req_brk(req_brk), .cur_pc(cur_pc), .in_dslot(in_dslot),
        .br_target(br_target), .vec_base(vec_base), .msr_in(msr_in),
        .flush(flush), .new_pc(new_pc), .lr_we(lr_we), .lr_addr(lr_addr),
        .lr_data(lr_data), .msr_out(msr_out), .esr_we(esr_we), .esr_out(esr_out),
        .ear_we(ear_we), .ear_out(ear_out), .btr_we(btr_we), .btr_out(btr_out),
        .unsup_err(unsup_err), .fatal_err(fatal_err)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // 0 none, 1 fault, 2 exception, 3 break, 4 interrupt (R1, R9, R10)
    function automatic int pick_kind();
        if (req_mmu) return 1;
        if (req_hwexc && exc_supported) return 2;
        if (req_brk) return 3;
        if (req_irq && msr_in[1] && !msr_in[9] && !msr_in[3]) return 4;
        return 0;
    endfunction

    function automatic logic [31:0] exp_msr(input logic [31:0] m, input int k);
        logic [31:0] r;
        r = m;
        r[12] = m[11];
        r[14] = m[13];
        r[11] = 1'b0;
        r[13] = 1'b0;
        if (k == 1 || k == 2) r[9] = 1'b1;
        if (k == 3) r[3] = 1'b1;
        if (k == 4) r[1] = 1'b0;
        return r;
    endfunction

    function automatic logic [31:0] exp_esr(input int k);
        logic [31:0] r;
        r = '0;
        if (k == 1) begin
            r[4:0]  = mmu_prot ? (mmu_fetch ? 5'd19 : 5'd18) : (mmu_fetch ? 5'd17 : 5'd16);
            r[10]   = mmu_store;
            r[12]   = in_dslot;
        end else if (k == 2) begin
            r[4:0]  = exc_cause;
            r[12]   = in_dslot;
        end
        return r;
    endfunction

    task automatic clear_reqs();
        req_mmu = 1'b0; req_hwexc = 1'b0; req_brk = 1'b0; req_irq = 1'b0;
    endtask

    // drive at a falling edge; results due at the next falling edge
    task automatic run_trap(input bit hold);
        int k;
        logic [31:0] e_pc, e_lr, e_msr, e_esr;
        logic [4:0]  e_la;
        logic        e_uns, e_exc;
        k      = pick_kind();
        e_uns  = req_hwexc && !exc_supported;
        e_exc  = (k == 1 || k == 2);
        e_msr  = exp_msr(msr_in, k);
        e_esr  = exp_esr(k);
        e_pc   = vec_base + ((k == 4) ? 32'h10 : (k == 3) ? 32'h18 : 32'h20);
        e_la   = (k == 4) ? 5'd14 : (k == 3) ? 5'd16 : 5'd17;
        e_lr   = (k == 2) ? cur_pc + 32'd4 : cur_pc;
        @(negedge clk);
        check("R10", "unsup_err", 32'(unsup_err), 32'(e_uns));
        if (k == 0) begin
            check("R9", "no entry flush", 32'(flush), 32'd0);
        end else begin
            check("R11", "flush", 32'(flush), 32'd1);
            check("R11", "lr_we", 32'(lr_we), 32'd1);
            check("R2", "new_pc", new_pc, e_pc);
            check("R1", "lr_addr", 32'(lr_addr), 32'(e_la));
            check("R3", "lr_data", lr_data, e_lr);
            check("R5", "msr shadow", 32'(msr_out[14:11]), 32'(e_msr[14:11]));
            check("R6", "msr_out", msr_out, e_msr);
            check("R7", "esr_we", 32'(esr_we), 32'(e_exc));
            if (e_exc) begin
                check("R4", "esr dslot", 32'(esr_out[12]), 32'(in_dslot));
                check("R7", "esr_out", esr_out, e_esr);
            end
            check("R4", "btr_we", 32'(btr_we), 32'(e_exc && in_dslot));
            if (e_exc && in_dslot) check("R4", "btr_out", btr_out, br_target);
            check("R7", "ear_we", 32'(ear_we), 32'(k == 1));
            if (k == 1) check("R7", "ear_out", ear_out, fault_addr);
        end
        if (!hold) clear_reqs();
        @(negedge clk);
        check("R11", "flush after commit", 32'(flush), 32'd0);
        if (hold) clear_reqs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        check("R12", "flush", 32'(flush), 32'd0);
        check("R12", "lr_we", 32'(lr_we), 32'd0);
        check("R12", "esr/ear/btr we", 32'({esr_we, ear_we, btr_we}), 32'd0);
        check("R12", "errors", 32'({unsup_err, fatal_err}), 32'd0);

        // hardware exception, plain and in a delay slot
        cur_pc = 32'h0000_1000; exc_cause = 5'd5; msr_in = 32'h0000_2802;
        req_hwexc = 1'b1; run_trap(0);
        in_dslot = 1'b1; br_target = 32'h0000_2220; req_hwexc = 1'b1; run_trap(0);
        in_dslot = 1'b0;

        // four translation fault codes, with store flag
        fault_addr = 32'hDEAD_BEE0; msr_in = 32'h0000_2000;
        for (int i = 0; i < 4; i++) begin
            mmu_prot = i[1]; mmu_fetch = i[0]; mmu_store = ~i[0];
            req_mmu = 1'b1; run_trap(0);
        end

        // interrupt accepted, then gated by IE, EIP and BIP (R9)
        msr_in = 32'h0000_0802; req_irq = 1'b1; run_trap(0);
        msr_in = 32'h0000_0000; req_irq = 1'b1; run_trap(0);
        msr_in = 32'h0000_0202; req_irq = 1'b1; run_trap(0);
        msr_in = 32'h0000_000A; req_irq = 1'b1; run_trap(0);

        // break, in delay slot (no branch target saved)
        msr_in = 32'h0000_2800; in_dslot = 1'b1; req_brk = 1'b1; run_trap(0);
        in_dslot = 1'b0;

        // priority (R1)
        msr_in = 32'h0000_0002;
        req_mmu = 1; req_hwexc = 1; req_brk = 1; req_irq = 1; run_trap(0);
        req_hwexc = 1; req_brk = 1; req_irq = 1; run_trap(0);
        req_brk = 1; req_irq = 1; run_trap(0);

        // unsupported exception alone, then with an interrupt (R10)
        exc_supported = 1'b0;
        req_hwexc = 1; run_trap(0);
        req_hwexc = 1; req_irq = 1; run_trap(0);
        exc_supported = 1'b1;

        // request held into the commit cycle is ignored (R11)
        req_brk = 1; run_trap(1);

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            req_mmu   = ($urandom % 5) == 0;
            req_hwexc = ($urandom % 4) == 0;
            req_brk   = ($urandom % 4) == 0;
            req_irq   = ($urandom % 2) == 0;
            exc_supported = ($urandom % 8) != 0;
            exc_cause = 5'($urandom);
            mmu_prot  = 1'($urandom); mmu_fetch = 1'($urandom); mmu_store = 1'($urandom);
            in_dslot  = 1'($urandom);
            cur_pc    = $urandom & 32'hFFFF_FFFC;
            br_target = $urandom & 32'hFFFF_FFFC;
            fault_addr = $urandom;
            vec_base  = $urandom & 32'hFFFF_FF00;
            msr_in    = $urandom;
            if (req_mmu) msr_in[9] = 1'b0;
            run_trap(0);
        end
        exc_supported = 1'b1;

        // recursive fault (R8)
        msr_in = 32'h0000_0000; req_mmu = 1; run_trap(0);
        msr_in = 32'h0000_0200; req_mmu = 1;
        @(negedge clk);
        check("R8", "fatal on recursive fault", 32'(fatal_err), 32'd1);
        check("R8", "no entry on recursive fault", 32'(flush), 32'd0);
        clear_reqs();
        msr_in = 32'h0000_0002; req_brk = 1; req_irq = 1;
        @(negedge clk);
        @(negedge clk);
        check("R8", "requests blocked when fatal", 32'(flush), 32'd0);
        check("R8", "fatal sticky", 32'(fatal_err), 32'd1);
        clear_reqs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R12", "fatal cleared by reset", 32'(fatal_err), 32'd0);
        check("R12", "flush after reset", 32'(flush), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule